// File: doc/BRIEF.md
# Character Output Register Pair

This block is the processor-facing side of a character output device. It offers two 16-bit registers on a simple read/write port: a status word and a transmit buffer. Address bit 1 picks one of the two. Address bit 0 marks an odd-byte access.

Software writes a character into the transmit buffer. This clears the ready flag, withdraws any interrupt request and starts a delay timer. When the timer expires:
- the character goes out on a valid/ready stream, masked to 7 or 8 bits;
- the ready flag comes back;
- if interrupts are enabled, an interrupt request is raised.

The ready flag is set out of reset, so the device can accept a character as soon as reset is released.

The delay is a parameter counted in clock cycles. A second buffer write while a character is still waiting restarts the delay and replaces that character. A downstream serializer takes each character from the stream.

Top module: `printer_tx_regs`

## Requirements
- R1: Address bit 1 selects the register: 0 is the status word and 1 is the transmit buffer. A status read returns done in bit 7 and interrupt-enable in bit 6, with every other bit zero. A buffer read returns the stored byte in bits 7:0, with bits 15:8 zero.
- R2: After reset, done is 1, interrupt-enable is 0, the request is 0, the buffer holds 0 and no character is offered on the stream.
- R3: A status write copies only data bit 6 into interrupt-enable, and done is not changed by it. A status write with address bit 0 set has no effect at all.
- R4: A status write that clears interrupt-enable drops the request at the next edge. A status write that sets interrupt-enable while done is 1 raises the request at the next edge. The request is never 1 unless both done and interrupt-enable are 1.
- R5: A buffer write with address bit 0 clear loads data bits 7:0 into the buffer. A buffer write with address bit 0 set leaves the buffer unchanged. Every buffer write clears done, drops the request and starts the delay.
- R6: Done returns to 1 exactly TX_DELAY clock edges after the edge that took the buffer write. At that same edge the request rises if interrupt-enable is 1.
- R7: At expiry, tx_valid rises with the buffer byte. In 7-bit mode (char_wide = 0), bit 7 of that byte is forced to 0. In 8-bit mode (char_wide = 1), the byte goes out unchanged. tx_valid and tx_data then hold until tx_ready is seen high.
- R8: Reading either register changes neither done, nor the request, nor the buffer.
- R9: A buffer write while a delay is running restarts the delay from the new write and replaces the character, so only the last character is emitted, once.
- R10: A reset during a running delay cancels it, and no character is emitted for that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Bit 1 selects the register, bit 0 marks an odd byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| char_wide | input | 1 | 1 = 8-bit characters, 0 = 7-bit |
| tx_valid | output | 1 | A character is offered |
| tx_data | output | 8 | Offered character |
| tx_ready | input | 1 | Downstream takes the character |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with TX_DELAY set to 5. At that value the whole window from a buffer write to expiry can be watched edge by edge. The bench checks that done is still 0 at the edge before expiry and is 1 at the expiry edge itself. The short delay also makes it cheap to restart the timer in the middle of the window and to reset in the middle of the window.

// File: rtl/prt_tx_pkg.sv
package prt_tx_pkg;
  localparam int BUS_W    = 16;
  localparam int CHAR_W   = 8;
  localparam int DONE_POS = 7;
  localparam int IE_POS   = 6;

  // Character as it leaves the block: the top bit is dropped in 7-bit mode.
  function automatic logic [CHAR_W-1:0] char_mask(input logic [CHAR_W-1:0] c,
                                                  input logic wide);
    return wide ? c : {1'b0, c[CHAR_W-2:0]};
  endfunction

  // Status word as seen on the bus.
  function automatic logic [BUS_W-1:0] status_word(input logic done, input logic ie);
    logic [BUS_W-1:0] w;
    w = '0;
    w[DONE_POS] = done;
    w[IE_POS]   = ie;
    return w;
  endfunction
endpackage

// File: rtl/prt_tx_timer.sv
module prt_tx_timer #(
  parameter int DELAY = 100,
  localparam int CW   = $clog2(DELAY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic expire
);
  logic [CW-1:0] count;

  assign expire = busy && (count == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      count <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      count <= CW'(DELAY);
    end else if (expire) begin
      busy  <= 1'b0;
      count <= '0;
    end else if (busy) begin
      count <= count - CW'(1);
    end
  end
endmodule

// File: rtl/prt_tx_status.sv
module prt_tx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic csr_wr,
  input  logic wdata_ie,
  input  logic buf_wr,
  input  logic expire,
  output logic done,
  output logic ie,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b1;
      ie   <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (buf_wr)      done <= 1'b0;
      else if (expire) done <= 1'b1;

      if (csr_wr) ie <= wdata_ie;

      if (buf_wr)                irq <= 1'b0;
      else if (csr_wr)           irq <= wdata_ie && (done || expire);
      else if (expire && ie)     irq <= 1'b1;
    end
  end
endmodule

// File: rtl/prt_tx_stream.sv
module prt_tx_stream #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         tx_ready,
  output logic         tx_valid,
  output logic [W-1:0] tx_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_data  <= load_data;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/printer_tx_regs.sv
module printer_tx_regs
  import prt_tx_pkg::*;
#(
  parameter int TX_DELAY = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              char_wide,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              irq
);
  // Named internal events
  logic wr_any, even_byte, csr_wr, buf_wr, buf_load;
  logic busy, expire, done, ie;
  logic [CHAR_W-1:0] txbuf;

  assign wr_any    = bus_req && bus_we;
  assign even_byte = !bus_addr[0];
  assign csr_wr    = wr_any && !bus_addr[1] && even_byte;
  assign buf_wr    = wr_any &&  bus_addr[1];
  assign buf_load  = buf_wr && even_byte;

  always_ff @(posedge clk) begin
    if (!rst_n)        txbuf <= '0;
    else if (buf_load) txbuf <= bus_wdata[CHAR_W-1:0];
  end

  prt_tx_timer #(.DELAY(TX_DELAY)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(buf_wr), .busy(busy), .expire(expire)
  );

  prt_tx_status u_status (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .wdata_ie(bus_wdata[IE_POS]),
    .buf_wr(buf_wr), .expire(expire), .done(done), .ie(ie), .irq(irq)
  );

  prt_tx_stream #(.W(CHAR_W)) u_stream (
    .clk(clk), .rst_n(rst_n), .load(expire && !buf_wr),
    .load_data(char_mask(txbuf, char_wide)), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data)
  );

  always_comb begin
    if (bus_addr[1]) bus_rdata = {{(BUS_W-CHAR_W){1'b0}}, txbuf};
    else             bus_rdata = status_word(done, ie);
  end
endmodule

// File: rtl/printer_tx_regs_chk.sv
module printer_tx_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       csr_wr,
  input logic       buf_wr,
  input logic       expire,
  input logic       busy,
  input logic       done,
  input logic       ie,
  input logic       irq,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data
);
  // R4
  irq_needs_done_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && ie));
  // R5
  buf_wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |=> (!done && !irq && busy));
  // R3
  csr_keeps_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !expire) |=> (done == $past(done)));
  // R6
  expire_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !buf_wr) |=> (done && tx_valid));
  // R6
  done_only_by_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(expire));
  // R7
  hold_until_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

bind printer_tx_regs printer_tx_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .buf_wr(buf_wr), .expire(expire),
  .busy(busy), .done(done), .ie(ie), .irq(irq), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data)
);

// File: tb/printer_tx_regs_tb.sv
`timescale 1ns/1ps
module printer_tx_regs_tb;
  localparam int DLY = 5;
  localparam logic [1:0] A_CSR = 2'b00, A_CSR_ODD = 2'b01, A_BUF = 2'b10, A_BUF_ODD = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'b00;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic char_wide = 1'b1;
  logic tx_valid, tx_ready = 1'b1, irq;
  logic [7:0] tx_data;

  int tests = 0, fails = 0, emits = 0;
  logic [7:0] last_char = '0;

  always #2.5 clk = ~clk;

  printer_tx_regs #(.TX_DELAY(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .char_wide(char_wide), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .irq(irq)
  );

  always @(negedge clk)
    if (rst_n && tx_valid && tx_ready) begin
      emits++;
      last_char = tx_data;
    end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_req = 1'b1; bus_we = 1'b0;
    #1 d = bus_rdata;
    bus_req = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    do_reset();
    bus_rd(A_CSR, d); chk("R2 status after reset", d, 16'h0080);
    bus_rd(A_BUF, d); chk("R2 buffer after reset", d, 16'h0000);
    chk("R2 irq/valid after reset", {irq, tx_valid}, 16'h0);
  endtask

  task automatic t_ie_irq();
    logic [15:0] d;
    bus_wr(A_CSR, 16'hFF40);
    bus_rd(A_CSR, d); chk("R3 only IE written", d, 16'h00C0);
    chk("R4 IE set with done raises irq", irq, 1'b1);
    bus_wr(A_CSR_ODD, 16'h0000);
    bus_rd(A_CSR, d); chk("R3 odd status write ignored", d, 16'h00C0);
    bus_wr(A_CSR, 16'h0080);
    bus_rd(A_CSR, d); chk("R1 R3 IE cleared", d, 16'h0080);
    chk("R4 IE clear drops irq", irq, 1'b0);
  endtask

  task automatic t_tx_wide();
    logic [15:0] d;
    int e0;
    e0 = emits;
    char_wide = 1'b1;
    bus_wr(A_BUF, 16'h12C1);
    repeat (DLY-1) @(posedge clk);
    bus_rd(A_CSR, d); chk("R6 done low before expiry", d, 16'h0000);
    @(posedge clk);
    bus_rd(A_CSR, d); chk("R6 done at expiry", d, 16'h0080);
    chk("R7 valid at expiry", tx_valid, 1'b1);
    chk("R7 8-bit char", tx_data, 16'h00C1);
    bus_rd(A_BUF, d); chk("R1 R5 buffer read", d, 16'h00C1);
    chk("R7 one emission", emits - e0, 1);
  endtask

  task automatic t_tx_narrow_hold();
    logic [15:0] d;
    char_wide = 1'b0;
    tx_ready = 1'b0;
    bus_wr(A_CSR, 16'h0040);
    bus_wr(A_BUF, 16'h00C1);
    chk("R5 write drops irq", irq, 1'b0);
    bus_wr(A_CSR, 16'h00C0);
    bus_rd(A_CSR, d); chk("R3 done not writable", d, 16'h0040);
    chk("R4 no irq while busy", irq, 1'b0);
    repeat (DLY+3) @(posedge clk);
    @(negedge clk);
    chk("R7 7-bit mask", tx_data, 16'h0041);
    chk("R7 held without ready", tx_valid, 1'b1);
    chk("R6 irq at expiry with IE", irq, 1'b1);
    bus_rd(A_BUF, d);
    bus_rd(A_CSR, d); chk("R8 read keeps status", d, 16'h00C0);
    chk("R8 read keeps irq", irq, 1'b1);
    tx_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7 released by ready", tx_valid, 1'b0);
    bus_wr(A_CSR, 16'h0000);
    char_wide = 1'b1;
  endtask

  task automatic t_odd_byte();
    logic [15:0] d;
    bus_wr(A_BUF_ODD, 16'h5A5A);
    bus_rd(A_BUF, d); chk("R5 odd buffer write keeps data", d, 16'h00C1);
    bus_rd(A_CSR, d); chk("R5 odd buffer write clears done", d, 16'h0000);
    repeat (DLY+1) @(posedge clk);
    bus_rd(A_CSR, d); chk("R5 done after odd write", d, 16'h0080);
  endtask

  task automatic t_restart();
    logic [15:0] d;
    int e0;
    repeat (2) @(posedge clk);
    e0 = emits;
    bus_wr(A_BUF, 16'h0041);
    repeat (2) @(posedge clk);
    bus_wr(A_BUF, 16'h0042);
    repeat (DLY-1) @(posedge clk);
    bus_rd(A_CSR, d); chk("R9 timer restarted", d, 16'h0000);
    @(posedge clk);
    bus_rd(A_CSR, d); chk("R9 done after restarted delay", d, 16'h0080);
    repeat (2) @(posedge clk);
    chk("R9 single emission", emits - e0, 1);
    chk("R9 replaced char", last_char, 16'h0042);
  endtask

  task automatic t_reset_cancel();
    logic [15:0] d;
    int e0;
    e0 = emits;
    bus_wr(A_BUF, 16'h0055);
    repeat (2) @(posedge clk);
    do_reset();
    repeat (DLY+3) @(posedge clk);
    chk("R10 no emission after reset", emits - e0, 0);
    bus_rd(A_CSR, d); chk("R10 done after reset", d, 16'h0080);
    bus_rd(A_BUF, d); chk("R10 buffer cleared", d, 16'h0000);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_ie_irq();
    t_tx_wide();
    t_tx_narrow_hold();
    t_odd_byte();
    t_restart();
    t_reset_cancel();
    finish_run();
  end
endmodule